// File: doc/BRIEF.md
# Grouped Interrupt Steering Aggregator

This block gathers a configurable number of level-sensitive interrupt lines, organised in groups of 64, and folds them onto one interrupt output chosen from a small set of channel outputs. Each line passes through a per-bit enable mask. A per-bit software force can raise it without any hardware source. The result is a pending status that software reads as 32-bit words to find the lines to service. A master disable bit silences the channel outputs without losing the pending state. A master status bit gives a one-read answer to whether anything is pending at all.

Software reaches the block through a plain word-addressed register port with a read strobe, a write strobe, an address, write data and read data. The port has no back-pressure: a write is taken on the clock edge where the write strobe is high. Read data is registered and appears on the cycle after the strobe. The mask, force and status banks are ordered in reverse, so the lowest interrupt numbers live in the highest word of each bank. The base address of each bank grows with the group count.

Top module: `irqs_steer`

## Requirements
- R1: An active-low reset clears the channel-control, mask, force and master-disable registers, so all channel outputs read low and those registers read back zero.
- R2: Interrupt number i maps to word index (2·GROUPS − 1 − i/32), bit i mod 32, in the mask, force and status banks alike. With GROUPS=1, line 33 is bit 1 of word 0 and line 0 is bit 0 of word 1.
- R3: Mask word n is at word address 1+n. A 1 enables its line and a 0 blocks it. Status bit = (line level OR force bit) AND mask bit.
- R4: Force word n is at word address 2·GROUPS·1+1+n, that is 2·GROUPS+1+n. A force bit set under an enabled mask makes the status bit 1 with its line low.
- R5: Status word n is at word address 4·GROUPS+1+n. It is read-only: writes to it change nothing. A status bit clears as soon as its line drops, when no force bit holds it.
- R6: Channel control is at word address 0 and keeps the low CH bits of a write. Channel output k is high one cycle after (any status bit set AND control bit k set AND master disable clear). Outputs whose control bit is 0 stay low.
- R7: The master disable register is at word address 6·GROUPS+1, bit 0. While it is 1, every channel output is low on the following cycle, and the pending status is kept.
- R8: The master status register is at word address 6·GROUPS+2. Bit 0 is the OR of all status bits, whatever the channel control and master disable hold. Its other bits read 0.
- R9: Reads of any address above 6·GROUPS+2 return zero. Writes there change no register.
- R10: Read data shows the addressed register on the cycle after the read strobe is high. It is zero on the cycle after a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64·GROUPS | Level-sensitive interrupt lines |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| chan_irq | output | CH | Channel interrupt outputs |

## Verification
A corrupted mask or force word shows at the ports two ways. It shows in the next status read, on the cycle after the strobe. It also shows in the channel output one cycle after the bad bit becomes the only pending source. A channel-control or master-disable flop stuck at a wrong value shows on the channel outputs within one cycle of any pending line. The master status read exposes a broken OR tree, because it is checked against pending patterns whose channel output is masked off. A reversed word index sends a known line into the wrong status word, and the first status read catches it.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_MASK,
    RK_FORCE,
    RK_STAT,
    RK_MDIS,
    RK_MSTAT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] idx;
  } reg_sel_t;
endpackage

// File: rtl/irqs_addr_dec.sv
module irqs_addr_dec
  import irqs_pkg::*;
#(
  parameter int unsigned GROUPS = 1,
  parameter int unsigned AW     = 8
) (
  input  logic [AW-1:0] addr,
  output reg_sel_t      sel
);
  localparam int unsigned W = 2 * GROUPS;
  localparam logic [AW-1:0] A_MASK  = AW'(1);
  localparam logic [AW-1:0] A_FORCE = AW'(1 + W);
  localparam logic [AW-1:0] A_STAT  = AW'(1 + 2 * W);
  localparam logic [AW-1:0] A_MDIS  = AW'(1 + 3 * W);
  localparam logic [AW-1:0] A_MSTAT = AW'(2 + 3 * W);

  always_comb begin
    sel.kind = RK_NONE;
    sel.idx  = '0;
    if (addr == '0) begin
      sel.kind = RK_CTRL;
    end else if (addr < A_FORCE) begin
      sel.kind = RK_MASK;
      sel.idx  = 16'(addr - A_MASK);
    end else if (addr < A_STAT) begin
      sel.kind = RK_FORCE;
      sel.idx  = 16'(addr - A_FORCE);
    end else if (addr < A_MDIS) begin
      sel.kind = RK_STAT;
      sel.idx  = 16'(addr - A_STAT);
    end else if (addr == A_MDIS) begin
      sel.kind = RK_MDIS;
    end else if (addr == A_MSTAT) begin
      sel.kind = RK_MSTAT;
    end
  end
endmodule

// File: rtl/irqs_regfile.sv
module irqs_regfile
  import irqs_pkg::*;
#(
  parameter int unsigned GROUPS = 1,
  parameter int unsigned CH     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  reg_sel_t                 sel,
  input  logic [DW-1:0]            wdata,
  output logic [2*GROUPS-1:0][DW-1:0] mask_w,
  output logic [2*GROUPS-1:0][DW-1:0] force_w,
  output logic [CH-1:0]            ctrl_q,
  output logic                     mdis_q
);
  localparam int unsigned W = 2 * GROUPS;

  for (genvar n = 0; n < W; n++) begin : g_word
    logic hit_mask, hit_force;
    assign hit_mask  = wr_en && (sel.kind == RK_MASK)  && (sel.idx == 16'(n));
    assign hit_force = wr_en && (sel.kind == RK_FORCE) && (sel.idx == 16'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_w[n]  <= '0;
        force_w[n] <= '0;
      end else begin
        if (hit_mask)  mask_w[n]  <= wdata;
        if (hit_force) force_w[n] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mdis_q <= 1'b0;
    end else if (wr_en) begin
      if (sel.kind == RK_CTRL) ctrl_q <= wdata[CH-1:0];
      if (sel.kind == RK_MDIS) mdis_q <= wdata[0];
    end
  end
endmodule

// File: rtl/irqs_status.sv
module irqs_status
  import irqs_pkg::*;
#(
  parameter int unsigned GROUPS = 1
) (
  input  logic [64*GROUPS-1:0]        irq_in,
  input  logic [2*GROUPS-1:0][DW-1:0] mask_w,
  input  logic [2*GROUPS-1:0][DW-1:0] force_w,
  output logic [2*GROUPS-1:0][DW-1:0] stat_w,
  output logic                        any_pend
);
  localparam int unsigned W = 2 * GROUPS;

  // Word n carries lines (W-1-n)*32 .. (W-1-n)*32+31.
  for (genvar n = 0; n < W; n++) begin : g_word
    assign stat_w[n] = (irq_in[(W-1-n)*DW +: DW] | force_w[n]) & mask_w[n];
  end

  assign any_pend = |stat_w;
endmodule

// File: rtl/irqs_chan_out.sv
module irqs_chan_out #(
  parameter int unsigned CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_pend,
  input  logic          mdis_q,
  input  logic [CH-1:0] ctrl_q,
  output logic [CH-1:0] chan_irq
);
  logic fire;
  assign fire = any_pend && !mdis_q;

  for (genvar k = 0; k < CH; k++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_irq[k] <= 1'b0;
      else        chan_irq[k] <= fire && ctrl_q[k];
    end
  end
endmodule

// File: rtl/irqs_steer.sv
module irqs_steer
  import irqs_pkg::*;
#(
  parameter int unsigned GROUPS = 1,
  parameter int unsigned CH     = 4,
  parameter int unsigned AW     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [64*GROUPS-1:0]  irq_in,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [CH-1:0]         chan_irq
);
  localparam int unsigned W  = 2 * GROUPS;
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  reg_sel_t                sel;
  logic [W-1:0][DW-1:0]    mask_w, force_w, stat_w;
  logic [CH-1:0]           ctrl_q;
  logic                    mdis_q;
  logic                    any_pend;
  logic [DW-1:0]           rd_val;

  irqs_addr_dec #(.GROUPS(GROUPS), .AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  irqs_regfile #(.GROUPS(GROUPS), .CH(CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .sel     (sel),
    .wdata   (wdata),
    .mask_w  (mask_w),
    .force_w (force_w),
    .ctrl_q  (ctrl_q),
    .mdis_q  (mdis_q)
  );

  irqs_status #(.GROUPS(GROUPS)) u_stat (
    .irq_in   (irq_in),
    .mask_w   (mask_w),
    .force_w  (force_w),
    .stat_w   (stat_w),
    .any_pend (any_pend)
  );

  irqs_chan_out #(.CH(CH)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_pend (any_pend),
    .mdis_q   (mdis_q),
    .ctrl_q   (ctrl_q),
    .chan_irq (chan_irq)
  );

  always_comb begin
    unique case (sel.kind)
      RK_CTRL:  rd_val = DW'(ctrl_q);
      RK_MASK:  rd_val = mask_w[sel.idx[IW-1:0]];
      RK_FORCE: rd_val = force_w[sel.idx[IW-1:0]];
      RK_STAT:  rd_val = stat_w[sel.idx[IW-1:0]];
      RK_MDIS:  rd_val = {{(DW-1){1'b0}}, mdis_q};
      RK_MSTAT: rd_val = {{(DW-1){1'b0}}, any_pend};
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else            rdata <= '0;
  end
endmodule

// File: rtl/irqs_steer_chk.sv
module irqs_steer_chk #(
  parameter int unsigned GROUPS = 1,
  parameter int unsigned CH     = 4,
  parameter int unsigned AW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [31:0]   rdata,
  input logic [CH-1:0] chan_irq,
  input logic [CH-1:0] ctrl_q,
  input logic          mdis_q,
  input logic          any_pend
);
  localparam logic [AW-1:0] A_LAST  = AW'(2 + 6 * GROUPS);
  localparam logic [AW-1:0] A_MSTAT = AW'(2 + 6 * GROUPS);

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> (chan_irq == '0));

  p_unselected_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chan_irq & ~$past(ctrl_q)) == '0));

  p_disable_silences_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdis_q |=> (chan_irq == '0));

  p_master_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MSTAT) |=> (rdata == {31'b0, $past(any_pend)}));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > A_LAST) |=> (rdata == '0));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

bind irqs_steer irqs_steer_chk #(.GROUPS(GROUPS), .CH(CH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .chan_irq (chan_irq),
  .ctrl_q   (ctrl_q),
  .mdis_q   (mdis_q),
  .any_pend (any_pend)
);

// File: tb/irqs_steer_tb.sv
module irqs_steer_tb;
  localparam int GROUPS = 1;
  localparam int CH     = 4;
  localparam int AW     = 8;
  // word addresses for GROUPS=1
  localparam logic [AW-1:0] A_CTRL = 0, A_M0 = 1, A_M1 = 2, A_F0 = 3, A_F1 = 4;
  localparam logic [AW-1:0] A_S0 = 5, A_S1 = 6, A_MDIS = 7, A_MSTAT = 8;

  // fields: lines 0..31, lines 32..63, mask0, mask1, force0, force1, exp stat0, exp stat1
  localparam logic [31:0] VEC [8][8] = '{
    '{32'h0000_0001, 32'h0,          32'h0,         32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         32'h0000_0001},
    '{32'h0000_0001, 32'h0,          32'h0,         32'h0,         32'h0,         32'h0,         32'h0,         32'h0},
    '{32'h0,         32'h8000_0000,  32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         32'h8000_0000, 32'h0},
    '{32'h0,         32'h0,          32'h0000_00FF, 32'h0,         32'h0000_00F0, 32'h0,         32'h0000_00F0, 32'h0},
    '{32'h0,         32'h0,          32'h0,         32'h0F00_0000, 32'h0,         32'hF000_0000, 32'h0,         32'h0},
    '{32'hAAAA_AAAA, 32'h5555_5555,  32'hFFFF_0000, 32'h0000_FFFF, 32'h0,         32'h0,         32'h5555_0000, 32'h0000_AAAA},
    '{32'h0000_000F, 32'h0,          32'h0,         32'h0000_00FF, 32'h0,         32'h0000_00F0, 32'h0,         32'h0000_00FF},
    '{32'h0,         32'h0,          32'h0,         32'h0,         32'h0,         32'h0,         32'h0,         32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [64*GROUPS-1:0] irq_in = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [CH-1:0] chan_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irqs_steer #(.GROUPS(GROUPS), .CH(CH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .chan_irq(chan_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [CH-1:0] sel;
    logic anyp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 chan after reset", 32'(chan_irq), 32'h0);
    rst_n = 1'b1;
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 32'h0);
    rd(A_M0, d);   chk("R1 mask0 reset", d, 32'h0);
    rd(A_M1, d);   chk("R1 mask1 reset", d, 32'h0);
    rd(A_F1, d);   chk("R1 force1 reset", d, 32'h0);
    rd(A_MDIS, d); chk("R1 mdis reset", d, 32'h0);

    // vector table: R2 R3 R4 R6 R8
    for (int v = 0; v < 8; v++) begin
      sel = CH'(1) << (v % CH);
      wr(A_M0, VEC[v][2]); wr(A_M1, VEC[v][3]);
      wr(A_F0, VEC[v][4]); wr(A_F1, VEC[v][5]);
      wr(A_CTRL, 32'(sel));
      @(negedge clk); irq_in = {VEC[v][1], VEC[v][0]};
      settle();
      anyp = (VEC[v][6] | VEC[v][7]) != 0;
      rd(A_S0, d); chk("R3 R4 status word0", d, VEC[v][6]);
      rd(A_S1, d); chk("R2 R3 status word1", d, VEC[v][7]);
      chk("R6 channel output", 32'(chan_irq), anyp ? 32'(sel) : 32'h0);
      rd(A_MSTAT, d); chk("R8 master status", d, {31'b0, anyp});
    end

    // R2 line 33 lands in word0 bit1
    wr(A_M0, 32'hFFFF_FFFF); wr(A_M1, 32'h0); wr(A_F0, 0); wr(A_F1, 0);
    @(negedge clk); irq_in = '0; irq_in[33] = 1'b1;
    settle();
    rd(A_S0, d); chk("R2 line33 word0", d, 32'h0000_0002);
    // R5 level clear
    @(negedge clk); irq_in = '0;
    rd(A_S0, d); chk("R5 level clears", d, 32'h0);
    // R5 read-only
    @(negedge clk); irq_in[33] = 1'b1;
    wr(A_S0, 32'h0); wr(A_S1, 32'hFFFF_FFFF);
    rd(A_S0, d); chk("R5 status write ignored", d, 32'h0000_0002);
    rd(A_S1, d); chk("R5 status1 write ignored", d, 32'h0);
    rd(A_M0, d); chk("R5 mask intact", d, 32'hFFFF_FFFF);

    // R7 master disable
    wr(A_CTRL, 32'h2); settle();
    chk("R6 selected channel", 32'(chan_irq), 32'h2);
    wr(A_MDIS, 32'h1); settle();
    chk("R7 disable silences", 32'(chan_irq), 32'h0);
    rd(A_MDIS, d); chk("R7 disable readback", d, 32'h1);
    rd(A_MSTAT, d); chk("R8 mstat under disable", d, 32'h1);
    rd(A_S0, d); chk("R7 status kept", d, 32'h2);
    wr(A_MDIS, 32'h0); settle();
    chk("R7 re-enable", 32'(chan_irq), 32'h2);

    // R6 several bits, then none
    wr(A_CTRL, 32'hFFFF_FFF9); settle();
    chk("R6 two channels", 32'(chan_irq), 32'h9);
    rd(A_CTRL, d); chk("R6 ctrl keeps CH bits", d, 32'h9);
    wr(A_CTRL, 32'h0); settle();
    chk("R6 no channel", 32'(chan_irq), 32'h0);
    rd(A_MSTAT, d); chk("R8 mstat no channel", d, 32'h1);

    // R9 unmapped
    rd(8'd9, d);   chk("R9 unmapped read", d, 32'h0);
    rd(8'd200, d); chk("R9 far unmapped read", d, 32'h0);
    wr(8'd9, 32'hFFFF_FFFF);
    rd(A_M1, d);   chk("R9 write no effect mask1", d, 32'h0);
    rd(A_F0, d);   chk("R9 write no effect force0", d, 32'h0);
    rd(A_CTRL, d); chk("R9 write no effect ctrl", d, 32'h0);

    // R10 read timing
    @(negedge clk); rd_en = 1'b1; addr = A_M0;
    @(negedge clk); chk("R10 data after strobe", rdata, 32'hFFFF_FFFF);
    rd_en = 1'b0;
    @(negedge clk); chk("R10 zero without strobe", rdata, 32'h0);

    // R1 reset mid-run
    wr(A_CTRL, 32'h1); settle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R1 chan in reset", 32'(chan_irq), 32'h0);
    rst_n = 1'b1;
    rd(A_M0, d); chk("R1 mask cleared", d, 32'h0);
    rd(A_CTRL, d); chk("R1 ctrl cleared", d, 32'h0);

    finish_run();
  end
endmodule